// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the bus-facing half of a 2048-byte non-volatile memory that is reached over a two-wire I2C bus. It oversamples the clock and data lines with a fast system clock and removes short glitches from both. It recognises START and STOP conditions and moves bytes most significant bit first. It acknowledges or refuses each byte by enabling an open-drain pull-down on the data line. One 11-bit address pointer serves both directions. The three upper pointer bits come from the device select byte and the eight lower bits from a word address byte.

A master stores bytes by sending a write select byte, a word address and one or more data bytes. The block hands each accepted byte to the memory port and steps the pointer inside a 32-byte page. A master reads by sending a read select byte, either on its own (the read starts at the current pointer) or after a word address and a repeated START (random read). It then keeps reading for as long as it acknowledges. A write-protect input refuses data bytes. A busy input from the separate write sequencer makes the block ignore its own select byte. A one-cycle commit pulse tells that sequencer that a STOP has closed a transfer in which at least one byte was stored.

Top module: `serial_nvm_target`

## Requirements
- R1: After reset the data-line pull-down is off, no memory write is issued and the pointer output is 0.
- R2: A select byte whose upper four bits are 1010 is acknowledged. Any other code is refused, and every later byte is ignored until the next START.
- R3: Select byte bits 3..1 load pointer bits 10..8. In a write transfer the byte after the select byte loads pointer bits 7..0.
- R4: With write-protect low, every data byte in a write transfer is acknowledged. It is presented on the memory port for exactly one cycle, at the current pointer.
- R5: After each stored byte only pointer bits 4..0 increment. Bits 10..5 stay fixed, so 0x51F is followed by 0x500.
- R6: With write-protect high, the select byte and the word address are still acknowledged, but no data byte is acknowledged and no memory write occurs.
- R7: While the busy input is high, the block's own select byte is not acknowledged.
- R8: Read data leaves MSB first from the pointer. After each byte all 11 pointer bits increment, so 0x51F is followed by 0x520 and 0x7FF by 0x000.
- R9: A read that has no word address returns the byte at the current pointer. When the master does not acknowledge a byte, the block releases the data line and waits for a new START or STOP.
- R10: A STOP that ends a transfer in which at least one byte was stored raises the commit output for exactly one cycle. A transfer that stored nothing raises no commit pulse.
- R11: A pulse on either line that is shorter than FILT_CYC system clocks has no effect. The pull-down turns on only while the filtered clock is low.
- R12: A word address write, then a repeated START and a read select byte, returns data starting at that word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| wp | input | 1 | Write protect, high refuses data bytes |
| busy | input | 1 | Internal write cycle in progress |
| mem_addr | output | 11 | Address pointer presented to the memory |
| mem_rdata | input | 8 | Byte read from the memory at mem_addr, combinational |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to store when mem_we is high |
| wr_commit | output | 1 | One-cycle pulse when a STOP ends a transfer that stored bytes |

## Verification
A wrong bit counter or a misplaced state change shows up within one byte time. The acknowledge slot then carries a refusal where an acknowledge belongs, or the next read byte comes out shifted. A corrupted pointer does not show at once. It appears on the next read as a byte from the wrong address, or as a stored byte that lands outside its 32-byte page. That is why every write in the bench is read back over the bus, and why the pointer is checked at page and array boundaries. A filter that lets a glitch through aborts the byte in progress, and that byte's acknowledge goes missing.

// File: rtl/nvm_tgt_pkg.sv
package nvm_tgt_pkg;

    // Protocol phases of the target
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for START
        ST_DEV   = 3'd1,   // shifting in the select byte
        ST_ADDR  = 3'd2,   // shifting in the word address
        ST_WDATA = 3'd3,   // shifting in a data byte
        ST_ACK   = 3'd4,   // target-driven acknowledge slot
        ST_RDATA = 3'd5,   // shifting out a data byte
        ST_RACK  = 3'd6    // master acknowledge slot after a read byte
    } tgt_state_e;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);

    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw};
        if (q.sync[1] != q.out) begin
            if (q.cnt == CW'(FILT_CYC - 1)) begin
                d.out = q.sync[1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.out  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign filt = q.out;

endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_f;
        d.sda = sda_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign ev_start = scl_f & q.scl & q.sda & ~sda_f;
    assign ev_stop  = scl_f & q.scl & ~q.sda & sda_f;
    assign ev_rise  = scl_f & ~q.scl;
    assign ev_fall  = ~scl_f & q.scl;

endmodule

// File: rtl/serial_nvm_target.sv
module serial_nvm_target
    import nvm_tgt_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter int         PAGE_W   = 5,
    parameter int         FILT_CYC = 4,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              wp,
    input  logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              wr_commit
);

    localparam int BLK_W   = ADDR_W - 8;
    localparam int N_LINES = 2;

    // ---------------- input conditioning ----------------
    logic [N_LINES-1:0] raw_l;
    logic [N_LINES-1:0] filt_l;
    logic               scl_f;
    logic               sda_f;

    assign raw_l = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_l[g]),
            .filt  (filt_l[g])
        );
    end

    assign scl_f = filt_l[0];
    assign sda_f = filt_l[1];

    logic ev_start, ev_stop, ev_rise, ev_fall;

    bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    // ---------------- protocol engine ----------------
    typedef struct packed {
        tgt_state_e        st;
        tgt_state_e        nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              we;
        logic              wrote;
        logic              commit;
        logic              mnack;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.commit = 1'b0;

        // page-local step one cycle after a stored byte
        if (q.we) begin
            d.ptr = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + 1'b1};
        end

        if (ev_stop) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.cnt    = '0;
            d.commit = q.wrote;
            d.wrote  = 1'b0;
        end else if (ev_start) begin
            d.st  = ST_DEV;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (ev_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 4'd1;
                    end else if (ev_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:4] == DEV_CODE && !busy) begin
                                d.ptr[ADDR_W-1:8] = q.sh[BLK_W:1];
                                d.oe  = 1'b1;
                                d.st  = ST_ACK;
                                d.nxt = q.sh[0] ? ST_RDATA : ST_ADDR;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.ptr[7:0] = q.sh;
                            d.oe  = 1'b1;
                            d.st  = ST_ACK;
                            d.nxt = ST_WDATA;
                        end else begin
                            d.st  = ST_ACK;
                            d.nxt = ST_WDATA;
                            if (!wp) begin
                                d.oe    = 1'b1;
                                d.we    = 1'b1;
                                d.wrote = 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        d.cnt = '0;
                        d.st  = q.nxt;
                        if (q.nxt == ST_RDATA) begin
                            d.sh = mem_rdata;
                            d.oe = ~mem_rdata[7];
                        end else begin
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_RACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        d.mnack = sda_f;
                    end else if (ev_fall) begin
                        if (q.mnack) begin
                            d.st = ST_IDLE;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = mem_rdata;
                            d.oe  = ~mem_rdata[7];
                            d.cnt = '0;
                            d.st  = ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign mem_addr  = q.ptr;
    assign mem_we    = q.we;
    assign mem_wdata = q.sh;
    assign wr_commit = q.commit;

endmodule

// File: rtl/nvm_target_checks.sv
module nvm_target_checks #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              sda_oe,
    input logic              wp,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_commit
);

    // R11: pull-down only switches on while the filtered clock is low
    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R6: no write strobe after write-protect was high
    p_no_write_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wp));

    // R4: write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5: page bits hold across a stored byte
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(mem_addr[ADDR_W-1:PAGE_W]));

    // R5: offset inside page steps by one, wrapping
    p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1)));

    // R10: commit is a single-cycle pulse
    p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

bind serial_nvm_target nvm_target_checks #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .wp        (wp),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .wr_commit (wr_commit)
);

// File: tb/test_serial_nvm_target.sv
`timescale 1ns/1ps
module test_serial_nvm_target;

    localparam int AW = 11;
    localparam int Q  = 25;   // system clocks per quarter bus bit

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          wp = 1'b0;
    logic          busy = 1'b0;
    logic          sda_oe;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic          wr_commit;
    logic          sda_line;

    int checks = 0;
    int fails  = 0;
    int commits = 0;
    bit done = 1'b0;

    logic [7:0] mem [0:(1<<AW)-1];

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    serial_nvm_target i_serial_nvm_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .wp        (wp),
        .busy      (busy),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .wr_commit (wr_commit)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= init_val(i);
            commits <= 0;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (wr_commit) commits <= commits + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq();
            if (glitch && i == 7) begin
                sda_m = 1'b0;
                repeat (2) @(negedge clk);
                sda_m = 1'b1;
            end
            wq();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = !sda_line;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            v[i] = sda_line;
            wq();
            scl_m = 1'b0;
        end
        sda_m = !mack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] sel(input int blk, input bit rd);
        return {4'b1010, 3'(blk), rd};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 mem_addr", mem_addr, 0);
        wq();

        // R2 R3 R4 R5 R10: four bytes from 0x51E wrap inside the page
        c0 = commits;
        bus_start();
        wbyte(sel(5, 0), 0, ack); chk("R2 select ack", ack, 1);
        wbyte(8'h1E, 0, ack);     chk("R3 word addr ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            wbyte(8'hA0 + 8'(k), 0, ack); chk("R4 data ack", ack, 1);
        end
        bus_stop();
        wq();
        chk("R4 mem 51E", mem[11'h51E], 8'hA0);
        chk("R4 mem 51F", mem[11'h51F], 8'hA1);
        chk("R5 wrap to 500", mem[11'h500], 8'hA2);
        chk("R5 wrap to 501", mem[11'h501], 8'hA3);
        chk("R5 no spill 520", mem[11'h520], init_val(11'h520));
        chk("R10 commit once", commits - c0, 1);

        // R2 wrong device code, later bytes ignored
        c0 = commits;
        bus_start();
        wbyte(8'hB0, 0, ack); chk("R2 bad code nack", ack, 0);
        wbyte(8'h00, 0, ack); chk("R2 ignored byte nack", ack, 0);
        wbyte(8'h55, 0, ack); chk("R2 ignored byte nack", ack, 0);
        bus_stop();
        wq();
        chk("R2 no commit", commits - c0, 0);

        // R6 write protect
        wp = 1'b1;
        c0 = commits;
        bus_start();
        wbyte(sel(3, 0), 0, ack); chk("R6 select ack", ack, 1);
        wbyte(8'h40, 0, ack);     chk("R6 addr ack", ack, 1);
        wbyte(8'h99, 0, ack);     chk("R6 data nack", ack, 0);
        wbyte(8'h98, 0, ack);     chk("R6 data nack", ack, 0);
        bus_stop();
        wq();
        wp = 1'b0;
        chk("R6 mem unchanged", mem[11'h340], init_val(11'h340));
        chk("R6 mem unchanged", mem[11'h341], init_val(11'h341));
        chk("R10 no commit when nothing stored", commits - c0, 0);

        // R7 busy
        busy = 1'b1;
        bus_start();
        wbyte(sel(5, 1), 0, ack); chk("R7 busy select nack", ack, 0);
        bus_stop();
        wq();
        busy = 1'b0;

        // R12 R8 random read across a page boundary
        bus_start();
        wbyte(sel(5, 0), 0, ack);
        wbyte(8'h1E, 0, ack);
        bus_start();
        wbyte(sel(5, 1), 0, ack); chk("R12 read select ack", ack, 1);
        rbyte(1, v); chk("R12 first byte", v, 8'hA0);
        rbyte(1, v); chk("R8 second byte", v, 8'hA1);
        rbyte(0, v); chk("R8 full increment 520", v, init_val(11'h520));
        bus_stop();
        wq();
        chk("R9 released after nack", sda_oe, 0);

        // R9 current address read
        bus_start();
        wbyte(sel(5, 1), 0, ack); chk("R9 select ack", ack, 1);
        rbyte(0, v); chk("R9 current address", v, init_val(11'h521));
        bus_stop();
        wq();

        // R8 array wrap 7FF -> 000
        bus_start();
        wbyte(sel(7, 0), 0, ack);
        wbyte(8'hFE, 0, ack);
        bus_start();
        wbyte(sel(7, 1), 0, ack);
        rbyte(1, v); chk("R8 7FE", v, init_val(11'h7FE));
        rbyte(1, v); chk("R8 7FF", v, init_val(11'h7FF));
        rbyte(0, v); chk("R8 wrap 000", v, init_val(0));
        bus_stop();
        wq();

        // R11 glitch on data during a high clock is filtered
        bus_start();
        wbyte(sel(2, 0), 0, ack);
        wbyte(8'h10, 0, ack);
        wbyte(8'hC3, 1, ack); chk("R11 glitch byte ack", ack, 1);
        bus_stop();
        wq();
        chk("R11 glitch byte stored", mem[11'h210], 8'hC3);

        // R3 sweep over every block
        for (int blk = 0; blk < 8; blk++) begin
            logic [7:0] lo;
            logic [7:0] dat;
            lo  = 8'(blk * 37 + 11);
            dat = 8'(blk * 17) ^ 8'h5A;
            bus_start();
            wbyte(sel(blk, 0), 0, ack);
            wbyte(lo, 0, ack);
            wbyte(dat, 0, ack); chk("R3 sweep ack", ack, 1);
            bus_stop();
            wq();
            chk("R3 sweep stored", mem[{3'(blk), lo}], dat);
            bus_start();
            wbyte(sel(blk, 0), 0, ack);
            wbyte(lo, 0, ack);
            bus_start();
            wbyte(sel(blk, 1), 0, ack);
            rbyte(0, v); chk("R3 sweep readback", v, dat);
            bus_stop();
            wq();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule